// File: doc/BRIEF.md
# Function-Unit Dependency Matrix

This block tracks hazards between the function units of an out-of-order core. Each unit owns a row of one-bit dependency latches: one set for read hazards and one for commit hazards. The issue logic loads a unit's row when it issues an operation to that unit. Bit j of the row means the operation must wait for unit j to commit. The block grants each unit a read permission (go-read), which lets it fetch operands and start executing. Separately, it grants a commit permission (go-write), which lets it write back the result it has buffered. Load and store units are ordinary rows of the same matrix.

Commit is held off by three things: a pending commit dependency, a write-hold input that a unit keeps raised until it knows no exception can occur, and a missing execution result. A kill input discards a mis-speculated operation. When a unit commits or is killed, every bit that other units hold against it is cleared on the same clock edge. With the ordering option on, each new operation also gains a commit dependency on every unit that is already busy, so results commit in issue order even when they finish out of order.

Top module: `fu_dep_matrix`

## Requirements
- R1: After reset every unit is idle: busy, go_read and go_write are all zero.
- R2: A unit issued with an empty read-dependency row raises go_read in the cycle after issue. A unit with any read-dependency bit set keeps go_read low.
- R3: go_write for a unit rises only after its exec_done has been seen in the cycle after its operands were read, and only while its commit row is empty. A unit may read and execute while older units are still uncommitted.
- R4: While wr_hold of a unit is high, its go_write stays low and its result stays pending (busy stays high). go_write rises in the first cycle after the hold drops.
- R5: go_die of a unit suppresses its go_write in the same cycle. The unit is idle in the next cycle, and read dependencies that other units hold against it are gone, so they may read.
- R6: When a unit commits, every unit that depended on it sees that dependency cleared in the next cycle and raises go_read then.
- R7: With AUTO_ORDER set, units with no read dependencies commit one per cycle in issue order, even when all finish together. With AUTO_ORDER clear and no commit dependencies given, they all commit in the same cycle.
- R8: At issue, dependency bits that point at the issued unit itself, at an idle unit, or at a unit that commits or is killed in that same cycle are dropped.
- R9: issue_fu is the binary index of the unit being issued. In every per-unit vector and in both dependency masks, bit j refers to unit j.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | Issue an operation this cycle |
| issue_fu | input | IDXW | Index of the unit receiving the operation |
| issue_rd_dep | input | NUM_FU | Units whose results the operation reads |
| issue_wr_dep | input | NUM_FU | Units that must commit before this operation commits |
| exec_done | input | NUM_FU | Unit has finished executing and buffered its result |
| wr_hold | input | NUM_FU | Write-prevention: hold off commit |
| go_die | input | NUM_FU | Kill the unit's pending operation |
| go_read | output | NUM_FU | Operands may be read now |
| go_write | output | NUM_FU | Buffered result may commit now |
| busy | output | NUM_FU | Unit holds a pending operation |

## Verification
The assertions assume the issue logic never issues to a unit that is busy or being killed in the same cycle. They also assume exec_done is raised only while a unit is executing. Under those assumptions, a kill leaves the unit's row empty and a commit leaves its column empty on the following cycle. The bench waits for busy to fall before reusing any unit. It pulses exec_done only in cycles where it has worked out that the unit has read its operands. It sweeps every ordered pair of units through a dependent read chain, then applies hold, kill, same-cycle retire and ordering sequences.

// File: rtl/fudm_pkg.sv
package fudm_pkg;

   typedef enum logic [1:0] {
      FU_IDLE     = 2'd0,
      FU_WAIT_OPS = 2'd1,
      FU_EXEC     = 2'd2,
      FU_HELD     = 2'd3
   } fu_state_e;

   function automatic int unsigned fudm_idx_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/fudm_dep_cell.sv
module fudm_dep_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic din,
   input  logic clr,
   output logic q
);
   always_ff @(posedge clk) begin
      if (!rst_n)    q <= 1'b0;
      else if (load) q <= din;
      else if (clr)  q <= 1'b0;
   end
endmodule

// File: rtl/fudm_issue_mask.sv
module fudm_issue_mask #(
   parameter int NUM_FU     = 4,
   parameter bit AUTO_ORDER = 1'b1,
   localparam int IDXW      = fudm_pkg::fudm_idx_width(NUM_FU)
) (
   input  logic              issue_valid,
   input  logic [IDXW-1:0]   issue_fu,
   input  logic [NUM_FU-1:0] issue_rd_dep,
   input  logic [NUM_FU-1:0] issue_wr_dep,
   input  logic [NUM_FU-1:0] busy,
   input  logic [NUM_FU-1:0] retiring,
   output logic [NUM_FU-1:0] issue_hit,
   output logic [NUM_FU-1:0] rd_load,
   output logic [NUM_FU-1:0] wr_load
);
   logic [NUM_FU-1:0] live;
   logic [NUM_FU-1:0] wr_req;

   always_comb begin
      issue_hit = '0;
      for (int k = 0; k < NUM_FU; k++)
         issue_hit[k] = issue_valid && (issue_fu == IDXW'(k));
   end

   assign live = busy & ~retiring & ~issue_hit;

   generate
      if (AUTO_ORDER) begin : g_auto
         assign wr_req = issue_wr_dep | busy;
      end else begin : g_manual
         assign wr_req = issue_wr_dep;
      end
   endgenerate

   assign rd_load = issue_rd_dep & live;
   assign wr_load = wr_req & live;
endmodule

// File: rtl/fudm_unit_ctrl.sv
module fudm_unit_ctrl
   import fudm_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic issue_hit,
   input  logic rd_blocked,
   input  logic wr_blocked,
   input  logic exec_done,
   input  logic wr_hold,
   input  logic go_die,
   output logic go_read,
   output logic go_write,
   output logic busy
);
   fu_state_e st, st_nx;

   assign busy     = (st != FU_IDLE);
   assign go_read  = (st == FU_WAIT_OPS) && !rd_blocked && !go_die;
   assign go_write = (st == FU_HELD) && !wr_blocked && !wr_hold && !go_die;

   always_comb begin
      st_nx = st;
      unique case (st)
         FU_IDLE:     if (issue_hit) st_nx = FU_WAIT_OPS;
         FU_WAIT_OPS: if (go_read)   st_nx = FU_EXEC;
         FU_EXEC:     if (exec_done) st_nx = FU_HELD;
         FU_HELD:     if (go_write)  st_nx = FU_IDLE;
         default:                    st_nx = FU_IDLE;
      endcase
      if (go_die) st_nx = FU_IDLE;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) st <= FU_IDLE;
      else        st <= st_nx;
   end

   a_r4_hold_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hold |-> !go_write);
   a_r3_write_after_exec: assert property (@(posedge clk) disable iff (!rst_n)
      go_write |-> $past(exec_done) || $past(st == FU_HELD));
   a_r5_die_idles: assert property (@(posedge clk) disable iff (!rst_n)
      (go_die && !issue_hit) |=> !busy);
endmodule

// File: rtl/fu_dep_matrix.sv
module fu_dep_matrix
   import fudm_pkg::*;
#(
   parameter int NUM_FU     = 4,
   parameter bit AUTO_ORDER = 1'b1,
   localparam int IDXW      = fudm_idx_width(NUM_FU)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              issue_valid,
   input  logic [IDXW-1:0]   issue_fu,
   input  logic [NUM_FU-1:0] issue_rd_dep,
   input  logic [NUM_FU-1:0] issue_wr_dep,
   input  logic [NUM_FU-1:0] exec_done,
   input  logic [NUM_FU-1:0] wr_hold,
   input  logic [NUM_FU-1:0] go_die,
   output logic [NUM_FU-1:0] go_read,
   output logic [NUM_FU-1:0] go_write,
   output logic [NUM_FU-1:0] busy
);
   generate
      if (NUM_FU < 2)  begin : g_chk_lo $error("NUM_FU must be at least 2"); end
      if (NUM_FU > 64) begin : g_chk_hi $error("NUM_FU must not exceed 64"); end
   endgenerate

   logic [NUM_FU-1:0] rd_row  [NUM_FU];
   logic [NUM_FU-1:0] wr_row  [NUM_FU];
   logic [NUM_FU-1:0] rd_col  [NUM_FU];
   logic [NUM_FU-1:0] wr_col  [NUM_FU];
   logic [NUM_FU-1:0] issue_hit, rd_load, wr_load, col_clr;

   assign col_clr = go_write | go_die;

   fudm_issue_mask #(.NUM_FU(NUM_FU), .AUTO_ORDER(AUTO_ORDER)) u_mask (
      .issue_valid (issue_valid),
      .issue_fu    (issue_fu),
      .issue_rd_dep(issue_rd_dep),
      .issue_wr_dep(issue_wr_dep),
      .busy        (busy),
      .retiring    (col_clr),
      .issue_hit   (issue_hit),
      .rd_load     (rd_load),
      .wr_load     (wr_load)
   );

   generate
      for (genvar r = 0; r < NUM_FU; r++) begin : g_row
         for (genvar c = 0; c < NUM_FU; c++) begin : g_col
            fudm_dep_cell u_rd (
               .clk(clk), .rst_n(rst_n), .load(issue_hit[r]), .din(rd_load[c]),
               .clr(col_clr[c] | go_die[r]), .q(rd_row[r][c]));
            fudm_dep_cell u_wr (
               .clk(clk), .rst_n(rst_n), .load(issue_hit[r]), .din(wr_load[c]),
               .clr(col_clr[c] | go_die[r]), .q(wr_row[r][c]));
            assign rd_col[c][r] = rd_row[r][c];
            assign wr_col[c][r] = wr_row[r][c];
         end

         fudm_unit_ctrl u_ctrl (
            .clk       (clk),
            .rst_n     (rst_n),
            .issue_hit (issue_hit[r]),
            .rd_blocked(|rd_row[r]),
            .wr_blocked(|wr_row[r]),
            .exec_done (exec_done[r]),
            .wr_hold   (wr_hold[r]),
            .go_die    (go_die[r]),
            .go_read   (go_read[r]),
            .go_write  (go_write[r]),
            .busy      (busy[r])
         );

         a_r2_read_gated: assert property (@(posedge clk) disable iff (!rst_n)
            (|rd_row[r]) |-> !go_read[r]);
         a_r3_commit_row_empty: assert property (@(posedge clk) disable iff (!rst_n)
            go_write[r] |-> (wr_row[r] == '0));
         a_r6_column_cleared: assert property (@(posedge clk) disable iff (!rst_n)
            col_clr[r] |=> (rd_col[r] == '0) && (wr_col[r] == '0));
         a_r5_row_cleared: assert property (@(posedge clk) disable iff (!rst_n)
            (go_die[r] && !issue_hit[r]) |=> (rd_row[r] == '0) && (wr_row[r] == '0));
         a_r8_no_self_dep: assert property (@(posedge clk) disable iff (!rst_n)
            !rd_row[r][r] && !wr_row[r][r]);
      end
   endgenerate

   a_r1_idle_no_grant: assert property (@(posedge clk) disable iff (!rst_n)
      ((go_read | go_write) & ~busy) == '0);
endmodule

// File: tb/tb_fu_dep_matrix.sv
module tb_fu_dep_matrix;
   localparam int N = 4;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic issue_valid = 1'b0;
   logic [1:0] issue_fu = '0;
   logic [N-1:0] issue_rd_dep = '0, issue_wr_dep = '0;
   logic [N-1:0] exec_done = '0, wr_hold = '0, go_die = '0;
   logic [N-1:0] go_read, go_write, busy;
   logic [N-1:0] go_read2, go_write2, busy2;
   int checks = 0, errors = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   fu_dep_matrix #(.NUM_FU(N), .AUTO_ORDER(1'b1)) dut (
      .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_fu(issue_fu),
      .issue_rd_dep(issue_rd_dep), .issue_wr_dep(issue_wr_dep), .exec_done(exec_done),
      .wr_hold(wr_hold), .go_die(go_die), .go_read(go_read), .go_write(go_write), .busy(busy));

   fu_dep_matrix #(.NUM_FU(N), .AUTO_ORDER(1'b0)) dut2 (
      .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_fu(issue_fu),
      .issue_rd_dep(issue_rd_dep), .issue_wr_dep(issue_wr_dep), .exec_done(exec_done),
      .wr_hold(wr_hold), .go_die(go_die), .go_read(go_read2), .go_write(go_write2), .busy(busy2));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic nxt();
      @(negedge clk);
      issue_valid = 1'b0; issue_rd_dep = '0; issue_wr_dep = '0;
      exec_done = '0; go_die = '0;
   endtask

   task automatic issue(input int fu, input logic [N-1:0] rd, input logic [N-1:0] wr);
      issue_valid = 1'b1; issue_fu = 2'(fu); issue_rd_dep = rd; issue_wr_dep = wr;
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         checks++; errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1; #1;
      chk("R1 busy", 32'(busy), 0);
      chk("R1 go_read", 32'(go_read), 0);
      chk("R1 go_write", 32'(go_write | go_write2), 0);

      // Pair sweep: unit b reads the result of unit a (R2, R3, R6, R9)
      for (int a = 0; a < N; a++) begin
         for (int b = 0; b < N; b++) begin
            if (a == b) continue;
            nxt(); issue(a, '0, '0); #1;
            nxt(); #1;
            chk("R2 go_read after issue", 32'(go_read[a]), 1);
            issue(b, N'(1) << a, '0);
            nxt(); #1;
            chk("R2 dependent read blocked", 32'(go_read[b]), 0);
            chk("R3 no write before exec_done", 32'(go_write[a]), 0);
            exec_done[a] = 1'b1;
            nxt(); #1;
            chk("R3 go_write after exec_done", 32'(go_write[a]), 1);
            chk("R2 still blocked", 32'(go_read[b] | go_read2[b]), 0);
            nxt(); #1;
            chk("R6 column cleared by commit", 32'(go_read[b]), 1);
            chk("R6 producer idle", 32'(busy[a]), 0);
            nxt(); exec_done[b] = 1'b1; #1;
            nxt(); #1;
            chk("R3 consumer commits", 32'(go_write[b]), 1);
            nxt(); #1;
            chk("R1 all idle again", 32'(busy | busy2), 0);
         end
      end

      // R4: write hold
      nxt(); issue(1, '0, '0);
      nxt();
      nxt(); exec_done[1] = 1'b1;
      nxt(); wr_hold[1] = 1'b1; #1;
      chk("R4 held", 32'(go_write[1]), 0);
      nxt(); #1;
      chk("R4 held 2", 32'(go_write[1]), 0);
      chk("R4 result pending", 32'(busy[1]), 1);
      nxt(); wr_hold[1] = 1'b0; #1;
      chk("R4 released", 32'(go_write[1]), 1);
      nxt(); #1;
      chk("R4 idle", 32'(busy), 0);

      // R5: kill clears dependants
      nxt(); issue(0, '0, '0);
      nxt(); issue(1, 4'b0001, '0);
      nxt(); go_die[0] = 1'b1; #1;
      chk("R5 dependant blocked before kill", 32'(go_read[1]), 0);
      nxt(); #1;
      chk("R5 killed unit idle", 32'(busy[0]), 0);
      chk("R5 dependant released", 32'(go_read[1]), 1);
      nxt(); exec_done[1] = 1'b1;
      nxt(); #1;
      chk("R5 survivor commits", 32'(go_write[1]), 1);
      nxt();
      // R5: kill overrides grant
      nxt(); issue(2, '0, '0);
      nxt();
      nxt(); exec_done[2] = 1'b1;
      nxt(); go_die[2] = 1'b1; #1;
      chk("R5 kill suppresses go_write", 32'(go_write[2]), 0);
      nxt(); #1;
      chk("R5 idle after kill", 32'(busy), 0);

      // R8: masking at issue
      nxt(); issue(0, '0, '0);
      nxt();
      nxt(); exec_done[0] = 1'b1;
      nxt(); #1;
      chk("R8 producer commits", 32'(go_write[0]), 1);
      issue(1, 4'b1011, 4'b1011);
      nxt(); #1;
      chk("R8 stale bits dropped", 32'(go_read[1]), 1);
      nxt(); exec_done[1] = 1'b1;
      nxt(); #1;
      chk("R8 commit row empty", 32'(go_write[1]), 1);
      nxt(); #1;

      // R7: ordering, R3: execution ahead of commit
      nxt(); issue(2, '0, '0);
      nxt(); #1; chk("R3 read oldest", 32'(go_read[2]), 1); issue(0, '0, '0);
      nxt(); #1; chk("R3 read while older uncommitted", 32'(go_read[0]), 1); issue(3, '0, '0);
      nxt(); issue(1, '0, '0);
      nxt();
      nxt(); exec_done = 4'b1111;
      nxt(); #1;
      chk("R7 first commit", 32'(go_write), 32'b0100);
      chk("R7 unordered all commit", 32'(go_write2), 32'b1111);
      nxt(); #1; chk("R7 second commit", 32'(go_write), 32'b0001);
      nxt(); #1; chk("R7 third commit", 32'(go_write), 32'b1000);
      nxt(); #1; chk("R7 fourth commit", 32'(go_write), 32'b0010);
      nxt(); #1; chk("R7 drained", 32'(busy | busy2), 0);

      finished = 1;
      summary();
   end
endmodule